// File: doc/BRIEF.md
# Static Memory Access Timing Sequencer

This block paces accesses to an asynchronous static memory with up to four banks. A requester hands over one access at a time: a read or write flag, a sequential flag, a bank number, an address and write data. The sequencer then holds the chip select of that bank and the matching output-enable or write-enable strobe low for a programmed number of controller clock cycles. When the release of the data bus calls for it, it first inserts idle cycles with every chip select high.

Each bank has its own timing record, written through a simple configuration port. The record holds a write length code, a first-read length code, a page-read length code for sequential reads in an open page, a turnaround count and a long-write mode with its own ten-bit count. The length of an access is fixed when the request is accepted, so the record can be rewritten while an access is running. A one-cycle done pulse closes every access, and read data is returned with it.

Top module: `smc_timing_seq`

## Requirements
- R1: While reset is held and after it is released, every chip select, output enable and write enable is high (inactive), `req_ready` is 1 and `done` is 0.
- R2: With long-write mode off, a write keeps its chip select low for (w + 2) cycles for write code w of 0 to 30, and for 33 cycles for code 31. The reset value of the write code is 31.
- R3: With long-write mode on for the bank, a write lasts (x + 1) * 16 cycles for the 10-bit long-write count x, whatever the write code holds.
- R4: A read that is not a page read lasts (f + 1) cycles for the 5-bit first-read code f. The reset value of f is 31.
- R5: A read is a page read when the sequential flag is set, the previous access was a read of the same bank, and the address equals the previous address plus one. It lasts (p + 1) cycles for page code p, so code 31 (its reset value) gives 32 cycles.
- R6: When the bank or the read/write direction differs from the previous access, t idle cycles with all chip selects high come before the access. Here t is the 4-bit turnaround count of the previous bank, with reset value 15. No idle cycles are inserted otherwise, or before the first access after reset.
- R7: Configuration writes decode the bank from `cfg_addr[6:5]` (a 0x20 stride) and the field from `cfg_addr[4:2]`: 0 write code, 1 page code, 2 first-read code, 3 turnaround count, 4 long-write enable (bit 0), 5 long-write count. Data bits above each field's width have no effect.
- R8: A change to a bank's timing record made while an access is in flight leaves that access unchanged and applies from the next accepted access.
- R9: During an access, only the chip select of the addressed bank is low. Output enable is low only for reads and write enable only for writes. `mem_addr` and `mem_wdata` hold the request's values for the whole access.
- R10: `req_ready` is high only when no access or turnaround is running. `done` pulses for one cycle right after the last access cycle, and for a read `rd_data` then holds `mem_rdata` as sampled in that last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration address: bank in [6:5], field in [4:2] |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 for write, 0 for read |
| req_seq | input | 1 | Sequential access flag |
| req_bank | input | 2 | Target bank |
| req_addr | input | 24 | Access address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle access completion pulse |
| rd_data | output | 16 | Captured read data |
| mem_cs_n | output | 4 | Per-bank chip selects, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 24 | Address to the memory |
| mem_wdata | output | 16 | Data to the memory |
| mem_rdata | input | 16 | Data from the memory |

## Verification
On every cycle the assertions check that the two strobes are never low together, that address and data stay still through an access, that `req_ready` never coincides with an active chip select, and that `done` is a single-cycle pulse. They also check that each accepted write gets a length in the legal range for its mode. The exact length of each access, the choice between first-read and page-read timing, and whether a turnaround gap appears and how long it is can only be shown by the bench's scenarios, which count chip-select cycles against a model of the timing records. The same applies to the deferred effect of a rewrite during an access and to the masking of unused data bits.

// File: rtl/smc_pkg.sv
package smc_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int SMC_FW = 5;            // write, page and first-read code width
   localparam int SMC_TW = 4;            // turnaround count width
   localparam int SMC_XW = 10;           // long-write count width
   localparam int SMC_LW = SMC_XW + 5;   // length counter width, holds 1024*16

   typedef struct packed {
      logic              xen;
      logic [SMC_XW-1:0] xcnt;
      logic [SMC_TW-1:0] turn;
      logic [SMC_FW-1:0] first;
      logic [SMC_FW-1:0] page;
      logic [SMC_FW-1:0] wr;
   } bank_tim_t;

   typedef enum logic [1:0] {ST_IDLE, ST_TURN, ST_ACC} seq_st_t;
endpackage

// File: rtl/smc_bank_regs.sv
module smc_bank_regs
   import smc_pkg::*;
#(
   parameter int NBANK = 4,
   parameter int CAW   = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [CAW-1:0]         cfg_addr,
   input  logic [31:0]            cfg_wdata,
   output bank_tim_t [NBANK-1:0]  tab
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int BW = CAW - 5;

   if (CAW < 6) begin : g_bad_caw
      $error("smc_bank_regs: CAW must leave at least one bank bit");
   end

   // bits that no field uses; named so that lint accepts them
   logic unused_cfg;
   assign unused_cfg = ^{cfg_wdata[31:SMC_XW], cfg_addr[1:0]};

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      logic hit;
      assign hit = cfg_we && (cfg_addr[CAW-1:5] == BW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tab[g].wr    <= '1;
            tab[g].page  <= '1;
            tab[g].first <= '1;
            tab[g].turn  <= '1;
            tab[g].xen   <= 1'b0;
            tab[g].xcnt  <= '0;
         end else if (hit) begin
            case (cfg_addr[4:2])
               3'd0:    tab[g].wr    <= cfg_wdata[SMC_FW-1:0];
               3'd1:    tab[g].page  <= cfg_wdata[SMC_FW-1:0];
               3'd2:    tab[g].first <= cfg_wdata[SMC_FW-1:0];
               3'd3:    tab[g].turn  <= cfg_wdata[SMC_TW-1:0];
               3'd4:    tab[g].xen   <= cfg_wdata[0];
               3'd5:    tab[g].xcnt  <= cfg_wdata[SMC_XW-1:0];
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/smc_len_calc.sv
module smc_len_calc
   import smc_pkg::*;
(
   input  bank_tim_t          tim,
   input  logic               is_write,
   input  logic               is_page,
   output logic [SMC_LW-1:0]  len
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam logic [SMC_LW-1:0] WR_TOP_LEN = SMC_LW'(33);

   always_comb begin
      if (is_write) begin
         if (tim.xen)
            len = (SMC_LW'(tim.xcnt) + SMC_LW'(1)) << 4;
         else if (tim.wr == '1)
            len = WR_TOP_LEN;
         else
            len = SMC_LW'(tim.wr) + SMC_LW'(2);
      end else if (is_page) begin
         len = SMC_LW'(tim.page) + SMC_LW'(1);
      end else begin
         len = SMC_LW'(tim.first) + SMC_LW'(1);
      end
   end
endmodule

// File: rtl/smc_access_fsm.sv
module smc_access_fsm
   import smc_pkg::*;
#(
   parameter int NBANK = 4,
   parameter int BW    = 2,
   parameter int AW    = 24,
   parameter int DW    = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic               req_seq,
   input  logic [BW-1:0]      req_bank,
   input  logic [AW-1:0]      req_addr,
   input  logic [DW-1:0]      req_wdata,
   input  logic [SMC_LW-1:0]  acc_len,
   input  logic [SMC_TW-1:0]  turn_len,
   output logic               req_ready,
   output logic               page_hit,
   output logic [BW-1:0]      prev_bank,
   output logic [NBANK-1:0]   mem_cs_n,
   output logic               mem_oe_n,
   output logic               mem_we_n,
   output logic [AW-1:0]      mem_addr,
   output logic [DW-1:0]      mem_wdata,
   input  logic [DW-1:0]      mem_rdata,
   output logic               done,
   output logic [DW-1:0]      rd_data
);
   timeunit 1ns;
   timeprecision 100ps;

   seq_st_t            st;
   logic [SMC_LW-1:0]  cnt, len_q;
   logic [BW-1:0]      cur_bank;
   logic               cur_write, have_prev;
   logic               accept, dir_or_bank_chg, in_acc;

   assign accept          = req_valid && (st == ST_IDLE);
   assign dir_or_bank_chg = have_prev && ((req_bank != cur_bank) || (req_write != cur_write));
   assign page_hit        = have_prev && req_seq && !req_write && !cur_write &&
                            (req_bank == cur_bank) && (req_addr == mem_addr + AW'(1));
   assign prev_bank       = cur_bank;
   assign req_ready       = (st == ST_IDLE);
   assign in_acc          = (st == ST_ACC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         len_q     <= '0;
         cur_bank  <= '0;
         cur_write <= 1'b0;
         have_prev <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         done      <= 1'b0;
         rd_data   <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: if (accept) begin
               cur_bank  <= req_bank;
               cur_write <= req_write;
               mem_addr  <= req_addr;
               mem_wdata <= req_wdata;
               have_prev <= 1'b1;
               len_q     <= acc_len;
               if (dir_or_bank_chg && (turn_len != '0)) begin
                  st  <= ST_TURN;
                  cnt <= SMC_LW'(turn_len);
               end else begin
                  st  <= ST_ACC;
                  cnt <= acc_len;
               end
            end
            ST_TURN: begin
               if (cnt == SMC_LW'(1)) begin
                  st  <= ST_ACC;
                  cnt <= len_q;
               end else begin
                  cnt <= cnt - SMC_LW'(1);
               end
            end
            ST_ACC: begin
               if (cnt == SMC_LW'(1)) begin
                  st   <= ST_IDLE;
                  done <= 1'b1;
                  if (!cur_write) rd_data <= mem_rdata;
               end else begin
                  cnt <= cnt - SMC_LW'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   for (genvar g = 0; g < NBANK; g++) begin : g_cs
      assign mem_cs_n[g] = !(in_acc && (cur_bank == BW'(g)));
   end
   assign mem_oe_n = !(in_acc && !cur_write);
   assign mem_we_n = !(in_acc && cur_write);

   assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   assert_hold_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&mem_cs_n) && $past(!(&mem_cs_n))) |-> ($stable(mem_addr) && $stable(mem_wdata)));

   assert_ready_dark_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (&mem_cs_n));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/smc_timing_seq.sv
module smc_timing_seq
   import smc_pkg::*;
#(
   parameter int NBANK = 4,
   parameter int AW    = 24,
   parameter int DW    = 16,
   localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1,
   localparam int CAW  = 5 + BW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CAW-1:0]    cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_seq,
   input  logic [BW-1:0]     req_bank,
   input  logic [AW-1:0]     req_addr,
   input  logic [DW-1:0]     req_wdata,
   output logic              done,
   output logic [DW-1:0]     rd_data,
   output logic [NBANK-1:0]  mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic [DW-1:0]     mem_rdata
);
   timeunit 1ns;
   timeprecision 100ps;

   if (NBANK < 1 || NBANK > 8) begin : g_bad_nbank
      $error("smc_timing_seq: NBANK must lie in 1..8");
   end
   if (AW < 2 || DW < 1) begin : g_bad_width
      $error("smc_timing_seq: AW must be at least 2 and DW at least 1");
   end

   bank_tim_t [NBANK-1:0] tab;
   bank_tim_t             req_tim;
   logic [SMC_LW-1:0]     acc_len;
   logic [SMC_TW-1:0]     turn_len;
   logic                  page_hit;
   logic [BW-1:0]         prev_bank;

   assign req_tim  = tab[req_bank];
   assign turn_len = tab[prev_bank].turn;

   smc_bank_regs #(.NBANK(NBANK), .CAW(CAW)) u_regs (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .tab
   );

   smc_len_calc u_len (
      .tim(req_tim), .is_write(req_write), .is_page(page_hit), .len(acc_len)
   );

   smc_access_fsm #(.NBANK(NBANK), .BW(BW), .AW(AW), .DW(DW)) u_fsm (
      .clk, .rst_n, .req_valid, .req_write, .req_seq, .req_bank, .req_addr,
      .req_wdata, .acc_len, .turn_len, .req_ready, .page_hit, .prev_bank,
      .mem_cs_n, .mem_oe_n, .mem_we_n, .mem_addr, .mem_wdata, .mem_rdata,
      .done, .rd_data
   );

   assert_write_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_write && !req_tim.xen) |->
      (acc_len >= SMC_LW'(2) && acc_len <= SMC_LW'(33)));

   assert_long_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_write && req_tim.xen) |->
      (acc_len[3:0] == 4'd0 && acc_len != '0));
endmodule

// File: tb/sim_smc_timing_seq.sv
module sim_smc_timing_seq;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int NB  = 4;
   localparam int AW  = 24;
   localparam int DW  = 16;
   localparam int CAW = 7;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [CAW-1:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic req_valid = 1'b0, req_write = 1'b0, req_seq = 1'b0;
   logic [1:0] req_bank = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, done, mem_oe_n, mem_we_n;
   logic [DW-1:0] rd_data, mem_wdata, mem_rdata;
   logic [NB-1:0] mem_cs_n;
   logic [AW-1:0] mem_addr;

   always #2.5 clk = ~clk;   // 200 MHz

   smc_timing_seq #(.NBANK(NB), .AW(AW), .DW(DW)) u0 (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .req_valid, .req_ready,
      .req_write, .req_seq, .req_bank, .req_addr, .req_wdata, .done, .rd_data,
      .mem_cs_n, .mem_oe_n, .mem_we_n, .mem_addr, .mem_wdata, .mem_rdata
   );

   assign mem_rdata = mem_addr[DW-1:0] ^ 16'hA5C3;

   int n_chk = 0, n_err = 0;
   int sh_wr[NB], sh_pg[NB], sh_fr[NB], sh_tt[NB], sh_xen[NB], sh_xc[NB];
   bit m_have = 0, m_wr = 0;
   int m_bank = 0;
   logic [AW-1:0] m_addr = '0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cfg_wr(input int b, input int sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = {2'(b), 3'(sel), 2'b00}; cfg_wdata = d;
      case (sel)
         0: sh_wr[b]  = int'(d[4:0]);
         1: sh_pg[b]  = int'(d[4:0]);
         2: sh_fr[b]  = int'(d[4:0]);
         3: sh_tt[b]  = int'(d[3:0]);
         4: sh_xen[b] = int'(d[0]);
         5: sh_xc[b]  = int'(d[9:0]);
         default: ;
      endcase
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic int exp_len(input int b, input bit wr, input bit pg);
      if (wr) return (sh_xen[b] != 0) ? (sh_xc[b] + 1) * 16 : ((sh_wr[b] == 31) ? 33 : sh_wr[b] + 2);
      return pg ? sh_pg[b] + 1 : sh_fr[b] + 1;
   endfunction

   task automatic do_acc(input int b, input bit wr, input bit seq,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
      int el, et, gap, len;
      bit pg, sok;
      string lreq;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      pg = m_have && seq && !wr && !m_wr && (b == m_bank) && (a == m_addr + AW'(1));
      et = (m_have && (b != m_bank || wr != m_wr)) ? sh_tt[m_bank] : 0;
      el = exp_len(b, wr, pg);
      lreq = wr ? ((sh_xen[b] != 0) ? "R3 long write" : "R2 write") : (pg ? "R5 page read" : "R4 first read");
      m_have = 1; m_wr = wr; m_bank = b; m_addr = a;
      req_valid = 1'b1; req_write = wr; req_seq = seq; req_bank = 2'(b);
      req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      gap = 0;
      while (&mem_cs_n) begin gap++; @(negedge clk); end
      len = 0; sok = 1;
      while (!(&mem_cs_n)) begin
         if (~mem_cs_n != NB'(1 << b) || mem_oe_n != wr || mem_we_n != !wr ||
             mem_addr != a || (wr && mem_wdata != d) || req_ready) sok = 0;
         len++;
         @(negedge clk);
      end
      chk(gap == et, "R6 turnaround gap", gap, et);
      chk(len == el, lreq, len, el);
      chk(sok, "R9 strobes and hold", int'(sok), 1);
      chk(done == 1'b1 && req_ready, "R10 done pulse", int'(done), 1);
      if (!wr) chk(rd_data == (a[DW-1:0] ^ 16'hA5C3), "R10 read data",
                   int'(rd_data), int'(a[DW-1:0] ^ 16'hA5C3));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++; n_chk++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int s;
      s = $urandom(32'd6917);
      for (int i = 0; i < NB; i++) begin
         sh_wr[i] = 31; sh_pg[i] = 31; sh_fr[i] = 31; sh_tt[i] = 15; sh_xen[i] = 0; sh_xc[i] = 0;
      end
      repeat (3) @(negedge clk);
      chk(mem_cs_n == '1 && mem_oe_n && mem_we_n && req_ready && !done,
          "R1 in reset", int'(mem_cs_n), 15);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_cs_n == '1 && mem_oe_n && mem_we_n && req_ready && !done,
          "R1 after reset", int'(mem_cs_n), 15);

      // reset-value timing: top codes and default turnaround
      do_acc(0, 1, 0, 24'h100, 16'h1234);   // R2 code 31 -> 33
      do_acc(0, 0, 0, 24'h200, '0);         // R6 15 idle, R4 32
      do_acc(0, 0, 1, 24'h201, '0);         // R5 code 31 -> 32

      // R2 small code, bank change turnaround from previous bank
      cfg_wr(1, 0, 32'd0);
      cfg_wr(1, 3, 32'd0);
      do_acc(1, 1, 0, 24'h300, 16'hBEEF);
      do_acc(1, 1, 0, 24'h301, 16'h0F0F);   // no change -> no gap

      // R7 unused upper data bits have no effect
      cfg_wr(2, 0, 32'hFFFF_FFE3);
      cfg_wr(2, 3, 32'hFFFF_FFF2);
      do_acc(2, 1, 0, 24'h400, 16'h5555);   // 5 cycles
      do_acc(3, 1, 0, 24'h410, 16'h6666);   // gap 2 from bank 2

      // R3 long write overrides the write code
      cfg_wr(3, 0, 32'd0);
      cfg_wr(3, 5, 32'd2);
      cfg_wr(3, 4, 32'd1);
      do_acc(3, 1, 0, 24'h500, 16'h7777);   // 48
      cfg_wr(3, 5, 32'hFFFF_FC00);
      do_acc(3, 1, 0, 24'h501, 16'h8888);   // 16

      // R4/R5 page versus restart of first-read timing
      cfg_wr(1, 2, 32'd3);
      cfg_wr(1, 1, 32'd1);
      do_acc(1, 0, 0, 24'h010, '0);
      do_acc(1, 0, 1, 24'h011, '0);
      do_acc(1, 0, 1, 24'h013, '0);
      do_acc(1, 0, 0, 24'h014, '0);
      do_acc(1, 0, 1, 24'h015, '0);

      // R8 rewrite during an access applies to the next one
      cfg_wr(1, 0, 32'd8);
      fork
         do_acc(1, 1, 0, 24'h600, 16'hAAAA);
         begin repeat (4) @(negedge clk); cfg_wr(1, 0, 32'd1); end
      join
      do_acc(1, 1, 0, 24'h601, 16'hBBBB);

      // constrained random
      for (int b = 0; b < NB; b++) begin
         cfg_wr(b, 0, $urandom_range(0, 31));
         cfg_wr(b, 1, $urandom_range(0, 31));
         cfg_wr(b, 2, $urandom_range(0, 31));
         cfg_wr(b, 3, $urandom_range(0, 7));
         cfg_wr(b, 5, $urandom_range(0, 3));
         cfg_wr(b, 4, ($urandom_range(0, 3) == 0) ? 32'd1 : 32'd0);
      end
      for (int i = 0; i < 60; i++) begin
         int b;
         bit wr, sq;
         logic [AW-1:0] a;
         b  = $urandom_range(0, NB - 1);
         wr = ($urandom_range(0, 2) == 0);
         sq = ($urandom_range(0, 1) == 1);
         a  = ($urandom_range(0, 1) == 1) ? m_addr + AW'(1) : AW'($urandom);
         do_acc(b, wr, sq, a, DW'($urandom));
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule